// File: doc/BRIEF.md
# Load-multiple register transfer sequencer

This block runs a block load of several registers from consecutive memory words. A start strobe brings in a base address, a register-select mask with one bit per architectural register, a writeback flag and the index of the base register. The sequencer then reads one word per selected register, walking the mask from the lowest index to the highest. Each returned word leaves on a register-file write port together with its destination index.

The highest register index stands for the program counter. A word loaded for that slot never reaches the register file. It leaves as a branch target with a one-cycle branch request instead. After the final transfer the block reports completion and can update the base register to the address just past the loaded data. When the base register is itself one of the loaded registers, that final value is undefined. The block raises a dedicated flag for this case and drops the update.

Memory reads use a request/grant handshake for the address and a read-valid strobe for the data, so any memory latency is tolerated. No condition flags are produced.

Top module: `ldm_seq`

## Requirements
- R1: Reads go out in ascending register order. The first read address equals the base address, and every following read address is 4 bytes above the previous one.
- R2: While `mem_req_o` is high and `mem_gnt_i` is low, the request stays high and `mem_addr_o` holds its value into the next cycle.
- R3: In the cycle where `mem_rvalid_i` is high for a general register (index 0 to 14), `rf_we_o` is high, `rf_waddr_o` is that register's index and `rf_wdata_o` equals `mem_rdata_i`. In cycles with no returned word, `rf_we_o` and `branch_o` are low.
- R4: When mask bit 15 is set, the word for that slot is the last one read. In its return cycle `branch_o` is high, `branch_target_o` equals the returned word and `rf_we_o` is low. Index 15 is never written through the register-file port.
- R5: With writeback on and the base register absent from the mask, the done cycle carries `base_we_o` = 1, `base_waddr_o` = the base index and `base_wdata_o` = base + 4 × (number of set mask bits). With writeback off, `base_we_o` stays low.
- R6: With writeback on and the base register present in the mask, the done cycle carries `base_conflict_o` = 1 and `base_we_o` = 0. The conflict flag is never high together with `base_we_o`.
- R7: An all-zero mask issues no read. `done_o` rises in the cycle after the accepted strobe, and writeback, when enabled, writes the unchanged base.
- R8: `busy_o` is high from the cycle after an accepted strobe up to and including the done cycle. A strobe that arrives while busy is ignored and leaves the running transfer unchanged.
- R9: After reset the block is idle: `busy_o`, `done_o`, `mem_req_o`, `rf_we_o`, `branch_o` and `base_we_o` are all low.
- R10: `done_o` is a single-cycle pulse, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| base_addr_i | input | ADDR_W | Starting byte address |
| reg_mask_i | input | NREGS | Register-select mask, bit i selects register i |
| wback_i | input | 1 | Base-register update enable |
| base_idx_i | input | IDX_W | Index of the base register |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read byte address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | IDX_W | Register-file write index |
| rf_wdata_o | output | DATA_W | Register-file write data |
| branch_o | output | 1 | Branch request pulse |
| branch_target_o | output | DATA_W | Loaded branch target |
| base_we_o | output | 1 | Base-register update enable (done cycle) |
| base_waddr_o | output | IDX_W | Base-register index for the update |
| base_wdata_o | output | ADDR_W | Updated base address |
| base_conflict_o | output | 1 | Base register was in the list with writeback on |

## Verification
A register write or branch request is combinational from `mem_rvalid_i`. It is due in the same cycle as the returned word, so the bench raises the valid strobe at a falling edge and checks the write port one step later, before the next rising edge. The request address is due in the first cycle after an accepted strobe or after the previous return. The bench checks it in every cycle that the grant is held back. `done_o` and the base update follow one cycle after the last returned word, and one cycle after the strobe for an empty mask. Busy is checked low in the cycle after done. Grant and valid delays of zero to two cycles are swept, so each of these points is checked under several latencies.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_FIN  = 2'd3
   } ldm_state_e;
endpackage

// File: rtl/ldm_popcount.sv
module ldm_popcount #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < W; i++) begin
         cnt_o = cnt_o + CW'(vec_i[i]);
      end
   end
endmodule

// File: rtl/ldm_pick.sv
module ldm_pick #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic [W-1:0]  rest_o
);
   always_comb begin
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

   // clear lowest set bit
   assign rest_o = vec_i & (vec_i - W'(1));
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
   import ldm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NREGS      = 16,
   parameter int STEP       = 4,
   parameter bit BRANCH_TOP = 1'b1,
   localparam int IDX_W     = $clog2(NREGS),
   localparam int CNT_W     = $clog2(NREGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [NREGS-1:0]  reg_mask_i,
   input  logic              wback_i,
   input  logic [IDX_W-1:0]  base_idx_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              branch_o,
   output logic [DATA_W-1:0] branch_target_o,
   output logic              base_we_o,
   output logic [IDX_W-1:0]  base_waddr_o,
   output logic [ADDR_W-1:0] base_wdata_o,
   output logic              base_conflict_o
);
   if (NREGS < 2) begin : g_bad_nregs
      $error("ldm_seq: NREGS must be at least 2");
   end
   if (STEP < 1) begin : g_bad_step
      $error("ldm_seq: STEP must be positive");
   end

   ldm_state_e        state_q;
   logic [NREGS-1:0]  mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wb_q;
   logic              conf_q;
   logic [IDX_W-1:0]  bidx_q;

   logic [CNT_W-1:0]  start_cnt;
   logic [IDX_W-1:0]  cur_idx;
   logic [NREGS-1:0]  rest_mask;
   logic              take;
   logic              is_branch;

   ldm_popcount #(.W(NREGS), .CW(CNT_W)) i_cnt (
      .vec_i (reg_mask_i),
      .cnt_o (start_cnt)
   );

   ldm_pick #(.W(NREGS), .IW(IDX_W)) i_pick (
      .vec_i  (mask_q),
      .idx_o  (cur_idx),
      .rest_o (rest_mask)
   );

   if (BRANCH_TOP) begin : g_branch
      assign is_branch = (cur_idx == IDX_W'(NREGS - 1));
   end else begin : g_nobranch
      assign is_branch = 1'b0;
   end

   assign take = (state_q == ST_WAIT) && mem_rvalid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mask_q  <= '0;
         addr_q  <= '0;
         base_q  <= '0;
         cnt_q   <= '0;
         wb_q    <= 1'b0;
         conf_q  <= 1'b0;
         bidx_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mask_q  <= reg_mask_i;
                  addr_q  <= base_addr_i;
                  base_q  <= base_addr_i;
                  cnt_q   <= start_cnt;
                  wb_q    <= wback_i;
                  conf_q  <= wback_i && reg_mask_i[base_idx_i];
                  bidx_q  <= base_idx_i;
                  state_q <= (reg_mask_i == '0) ? ST_FIN : ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_gnt_i) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rvalid_i) begin
                  mask_q  <= rest_mask;
                  addr_q  <= addr_q + ADDR_W'(STEP);
                  state_q <= (rest_mask == '0) ? ST_FIN : ST_REQ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o          = (state_q != ST_IDLE);
   assign done_o          = (state_q == ST_FIN);
   assign mem_req_o       = (state_q == ST_REQ);
   assign mem_addr_o      = addr_q;
   assign rf_we_o         = take && !is_branch;
   assign rf_waddr_o      = cur_idx;
   assign rf_wdata_o      = mem_rdata_i;
   assign branch_o        = take && is_branch;
   assign branch_target_o = mem_rdata_i;
   assign base_we_o       = done_o && wb_q && !conf_q;
   assign base_waddr_o    = bidx_q;
   assign base_wdata_o    = base_q + ADDR_W'(cnt_q) * ADDR_W'(STEP);
   assign base_conflict_o = done_o && conf_q;

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

   // R1
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(STEP));

   // R4
   if (BRANCH_TOP) begin : g_pc_chk
      no_pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rf_we_o |-> rf_waddr_o != IDX_W'(NREGS - 1));
   end

   // R3
   one_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_we_o, branch_o}));

   // R6
   conflict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_conflict_o |-> !base_we_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   // R8
   busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R7
   empty_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && reg_mask_i == '0 |=> done_o && !mem_req_o);
endmodule

// File: tb/test_ldm_seq.sv
module test_ldm_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_in = '0;
   logic [15:0] mask_in = '0;
   logic        wb_in = 1'b0;
   logic [3:0]  idx_in = '0;
   logic        gnt = 1'b0;
   logic        rvalid = 1'b0;
   logic [31:0] rdata = '0;

   logic        busy_o, done_o, mem_req_o, rf_we_o, branch_o, base_we_o, base_conflict_o;
   logic [31:0] mem_addr_o, rf_wdata_o, branch_target_o, base_wdata_o;
   logic [3:0]  rf_waddr_o, base_waddr_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ldm_seq i_ldm_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_in),
      .reg_mask_i(mask_in), .wback_i(wb_in), .base_idx_i(idx_in),
      .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_gnt_i(gnt), .mem_rvalid_i(rvalid),
      .mem_rdata_i(rdata), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
      .rf_wdata_o(rf_wdata_o), .branch_o(branch_o),
      .branch_target_o(branch_target_o), .base_we_o(base_we_o),
      .base_waddr_o(base_waddr_o), .base_wdata_o(base_wdata_o),
      .base_conflict_o(base_conflict_o)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_op(input logic [31:0] base, input logic [15:0] mask,
                        input logic wb, input logic [3:0] idx,
                        input int gl, input int rl, input bit poke);
      logic [31:0] a;
      int pc;
      logic conf;
      @(negedge clk);
      start = 1'b1; base_in = base; mask_in = mask; wb_in = wb; idx_in = idx;
      @(negedge clk);
      start = 1'b0;
      #1 chk("R8 busy after start", 32'(busy_o), 32'd1);
      if (poke) begin
         // R8: strobe while busy must be ignored
         start = 1'b1; base_in = ~base; mask_in = ~mask; wb_in = ~wb; idx_in = idx + 4'd1;
      end
      a = base;
      pc = 0;
      for (int r = 0; r < 16; r++) begin
         if (mask[r]) begin
            pc++;
            for (int w = 0; w < gl; w++) begin
               #1 chk("R2 req held", 32'(mem_req_o), 32'd1);
               chk("R2 addr held", mem_addr_o, a);
               @(negedge clk);
               start = 1'b0;
            end
            gnt = 1'b1;
            #1 chk("R1 req", 32'(mem_req_o), 32'd1);
            chk("R1 addr order", mem_addr_o, a);
            @(negedge clk);
            gnt = 1'b0; start = 1'b0;
            for (int w = 0; w < rl; w++) begin
               #1 chk("R3 no write while waiting", 32'(rf_we_o | branch_o), 32'd0);
               @(negedge clk);
            end
            rvalid = 1'b1; rdata = memf(a);
            #1;
            if (r == 15) begin
               chk("R4 branch pulse", 32'(branch_o), 32'd1);
               chk("R4 branch target", branch_target_o, memf(a));
               chk("R4 no rf write", 32'(rf_we_o), 32'd0);
            end else begin
               chk("R3 rf we", 32'(rf_we_o), 32'd1);
               chk("R3 rf index", 32'(rf_waddr_o), 32'(r));
               chk("R3 rf data", rf_wdata_o, memf(a));
               chk("R4 no branch", 32'(branch_o), 32'd0);
            end
            @(negedge clk);
            rvalid = 1'b0;
            a = a + 32'd4;
         end
      end
      #1;
      start = 1'b0;
      conf = wb && mask[idx];
      chk("R7 R5 done due", 32'(done_o), 32'd1);
      chk("R7 no request at done", 32'(mem_req_o), 32'd0);
      chk("R6 conflict flag", 32'(base_conflict_o), 32'(conf));
      chk("R5 base we", 32'(base_we_o), 32'(wb && !conf));
      if (wb && !conf) begin
         chk("R5 base value", base_wdata_o, base + 32'(4 * pc));
         chk("R5 base index", 32'(base_waddr_o), 32'(idx));
      end
      @(negedge clk);
      #1 chk("R10 done single", 32'(done_o), 32'd0);
      chk("R10 idle after done", 32'(busy_o), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      // R9
      chk("R9 busy", 32'(busy_o), 32'd0);
      chk("R9 done", 32'(done_o), 32'd0);
      chk("R9 req", 32'(mem_req_o), 32'd0);
      chk("R9 writes", 32'({rf_we_o, branch_o, base_we_o}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 idle after release", 32'(busy_o), 32'd0);

      // R7 empty mask, with and without writeback
      do_op(32'h0000_1000, 16'h0000, 1'b1, 4'd3, 0, 0, 1'b0);
      do_op(32'h0000_2000, 16'h0000, 1'b0, 4'd3, 0, 0, 1'b1);
      // full list, only PC, all but PC
      do_op(32'h0001_0000, 16'hFFFF, 1'b1, 4'd2, 1, 1, 1'b0);
      do_op(32'h0001_0100, 16'h8000, 1'b1, 4'd2, 0, 2, 1'b1);
      do_op(32'hFFFF_FFF0, 16'h7FFF, 1'b1, 4'd15, 2, 0, 1'b0);

      // single-bit sweep, conflicting and clean base index
      for (int r = 0; r < 16; r++) begin
         do_op(32'h0000_4000 + 32'(r * 64), 16'(1 << r), 1'b1, 4'(r), r % 3, (r + 1) % 3, r[0]);
         do_op(32'h0000_8000 + 32'(r * 64), 16'(1 << r), 1'b1, 4'(r + 1), (r + 2) % 3, r % 3, 1'b0);
         do_op(32'h0000_C000 + 32'(r * 64), 16'(1 << r), 1'b0, 4'(r), 0, 0, 1'b0);
      end

      // random masks and bases
      for (int n = 0; n < 300; n++) begin
         do_op({$urandom()} & 32'hFFFF_FFFC, 16'($urandom()), 1'($urandom()),
               4'($urandom()), int'($urandom() % 3), int'($urandom() % 3), 1'($urandom()));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule